// File: doc/BRIEF.md
# Row/Column Broadcast Context Memory

This block is the configuration store that feeds an array of identical cells laid out in a square grid, eight lines on a side by default. It keeps two independent planes of 32-bit context words. The row plane holds one set of contexts for each row of the array, and the column plane holds one set for each column. Each set is sixteen contexts deep, so the default store is 2 x 8 x 16 = 256 words.

An execute command names a broadcast mode (row or column) and a context index. One clock edge later the block drives a wide context bus that carries one word per line. The block also fans that bus out to every cell. In row mode every cell of a row receives the same word. In column mode every cell of a column receives the same word. A per-cell strobe marks the cycle in which new contexts arrive.

A separate write port loads single words into either plane. The plane being broadcast is protected: a write to that plane is refused and flagged. Writes to the other plane proceed while the array keeps executing, so the next configuration can be staged without a stall.

Top module: `ctx_broadcast_mem`

## Requirements
- R1: After reset `ctx_bus`, `cell_ctx` and `cell_valid` are all zero, `bus_mode` is 0 (row), and `wr_error` is 0.
- R2: An accepted write with `wr_plane`=0, set s, index i and data d stores d. An execute with `exec_mode`=0 and index i then places row-plane set k, index i on `ctx_bus[k*32 +: 32]` for every k.
- R3: The same holds for the column plane, selected by `wr_plane`=1 and `exec_mode`=1.
- R4: When `bus_mode`=0, the cell at row r, column c sees `ctx_bus` word r on `cell_ctx[(r*8+c)*32 +: 32]`.
- R5: When `bus_mode`=1, that cell sees `ctx_bus` word c.
- R6: Bus data appear on the clock edge that samples the execute command. On that same edge `bus_mode` takes the command's mode and all 64 bits of `cell_valid` go high for exactly one cycle. In cycles with no execute, `cell_valid` is zero.
- R7: Without an execute, `ctx_bus` and `bus_mode` keep their last values, even while writes go to the other plane.
- R8: A write is refused in either of two cases: its plane is the live plane, or its plane matches an execute issued in the same cycle. The live plane is the mode of the most recent execute. A refused write leaves the stored word unchanged, and `wr_error` is high for one cycle on the next edge.
- R9: A write to a plane that is not live and not being executed in that cycle is stored and raises no error. Before the first execute after reset, both planes are writable.
- R10: The two planes are separate storage. The same set and index in the row plane and in the column plane hold independent words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| exec_valid | input | 1 | Execute command strobe |
| exec_mode | input | 1 | Broadcast mode of the command: 0 row, 1 column |
| exec_index | input | 4 | Context index within each set |
| wr_valid | input | 1 | Write request strobe |
| wr_plane | input | 1 | Target plane: 0 row, 1 column |
| wr_set | input | 3 | Target set (row or column number) |
| wr_index | input | 4 | Target context index |
| wr_data | input | 32 | Context word to store |
| wr_error | output | 1 | One-cycle flag for a refused write |
| ctx_bus | output | 256 | One 32-bit word per line, word k in bits k*32+31..k*32 |
| bus_mode | output | 1 | Mode of the contexts now on the bus |
| cell_valid | output | 64 | Per-cell strobe, bit r*8+c |
| cell_ctx | output | 2048 | Per-cell context, cell (r,c) in bits (r*8+c)*32 upward |

## Verification
A set decode or index fault shows as a wrong word in one lane of `ctx_bus` and in the matching cells, on the edge right after the execute. A stored word that was corrupted stays invisible until its index is next executed. For that reason the bench re-executes an index after every refused write to confirm the stored word did not change. If the record of which plane is live goes wrong, the effect shows on the very next edge after a write: `wr_error` is raised or missing there. A write that was wrongly accepted is seen only at the next execute of that plane.

// File: rtl/ctxm_pkg.sv
// Package: shared sizing defaults and the plane encoding for the context memory.
// Assumes a square array, so rows and columns share one line count.
package ctxm_pkg;
    localparam int unsigned LINES_DEF  = 8;
    localparam int unsigned DEPTH_DEF  = 16;
    localparam int unsigned WORD_W_DEF = 32;

    // Plane / broadcast mode encoding, shared by the write and execute ports
    typedef enum logic {
        PLANE_ROW = 1'b0,
        PLANE_COL = 1'b1
    } plane_e;
endpackage

// File: rtl/ctx_plane_bank.sv
// Module: one broadcast plane. It holds LINES sets of DEPTH words.
// The write port stores one word into one set. A read returns the word at the same
// index from every set at once, registered, and holds it until the next read.
// Assumes the caller never reads and writes the same plane in one cycle.
module ctx_plane_bank #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned DEPTH  = 16,
    parameter int unsigned WORD_W = 32,
    localparam int unsigned SET_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [SET_W-1:0]         wr_set,
    input  logic [IDX_W-1:0]         wr_index,
    input  logic [WORD_W-1:0]        wr_data,
    input  logic                     rd_en,
    input  logic [IDX_W-1:0]         rd_index,
    output logic [LINES*WORD_W-1:0]  rd_words
);
    for (genvar s = 0; s < LINES; s++) begin : g_set
        logic [WORD_W-1:0] mem [DEPTH];
        logic              sel;

        assign sel = wr_en && (wr_set == SET_W'(s));

        // Store the incoming word when this set is addressed
        always_ff @(posedge clk) begin
            if (sel) begin
                mem[wr_index] <= wr_data;
            end
        end

        // Capture this set's word at the read index and hold it between reads
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rd_words[s*WORD_W +: WORD_W] <= '0;
            end else if (rd_en) begin
                rd_words[s*WORD_W +: WORD_W] <= mem[rd_index];
            end
        end
    end
endmodule

// File: rtl/ctx_write_guard.sv
// Module: write admission. It tracks which plane is live, meaning the plane of the
// most recent execute. It refuses a write to the live plane, or to the plane an
// execute is reading in the same cycle, and flags each refusal one cycle later.
// Assumes no plane is live after reset until the first execute.
module ctx_write_guard (
    input  logic clk,
    input  logic rst_n,
    input  logic exec_valid,
    input  logic exec_mode,
    input  logic wr_valid,
    input  logic wr_plane,
    output logic wr_accept,
    output logic wr_error
);
    logic live_valid;
    logic live_plane;
    logic hits_exec;
    logic hits_live;
    logic conflict;

    // Decide whether the requested write would touch a plane in use
    always_comb begin
        hits_exec = exec_valid && (wr_plane == exec_mode);
        hits_live = live_valid && (wr_plane == live_plane);
        conflict  = wr_valid && (hits_exec || hits_live);
        wr_accept = wr_valid && !conflict;
    end

    // Remember the plane of the last execute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            live_valid <= 1'b0;
            live_plane <= 1'b0;
        end else if (exec_valid) begin
            live_valid <= 1'b1;
            live_plane <= exec_mode;
        end
    end

    // Report a refused write on the following cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_error <= 1'b0;
        end else begin
            wr_error <= conflict;
        end
    end
endmodule

// File: rtl/ctx_cell_fanout.sv
// Module: distributes the per-line bus to every cell. In row mode a cell takes
// its row's word; in column mode it takes its column's word.
// Purely combinational; assumes a LINES x LINES array.
module ctx_cell_fanout #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned WORD_W = 32
) (
    input  logic                            bus_mode,
    input  logic [LINES*WORD_W-1:0]         ctx_bus,
    output logic [LINES*LINES*WORD_W-1:0]   cell_ctx
);
    for (genvar r = 0; r < LINES; r++) begin : g_row
        for (genvar c = 0; c < LINES; c++) begin : g_col
            // Pick the row lane or the column lane for cell (r, c)
            assign cell_ctx[(r*LINES+c)*WORD_W +: WORD_W] =
                bus_mode ? ctx_bus[c*WORD_W +: WORD_W]
                         : ctx_bus[r*WORD_W +: WORD_W];
        end
    end
endmodule

// File: rtl/ctx_broadcast_mem.sv
// Module: top of the row/column broadcast context memory. It has two planes and a
// guarded write port. An execute reads one index from the chosen plane. The bus
// is valid one cycle after the command, and a one-cycle strobe goes to every cell.
// Assumes a square array of LINES x LINES cells.
module ctx_broadcast_mem
    import ctxm_pkg::*;
#(
    parameter int unsigned LINES  = LINES_DEF,
    parameter int unsigned DEPTH  = DEPTH_DEF,
    parameter int unsigned WORD_W = WORD_W_DEF,
    localparam int unsigned SET_W = (LINES > 1) ? $clog2(LINES) : 1,
    localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int unsigned BUS_W = LINES * WORD_W,
    localparam int unsigned CELLS = LINES * LINES
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    exec_valid,
    input  logic                    exec_mode,
    input  logic [IDX_W-1:0]        exec_index,
    input  logic                    wr_valid,
    input  logic                    wr_plane,
    input  logic [SET_W-1:0]        wr_set,
    input  logic [IDX_W-1:0]        wr_index,
    input  logic [WORD_W-1:0]       wr_data,
    output logic                    wr_error,
    output logic [BUS_W-1:0]        ctx_bus,
    output logic                    bus_mode,
    output logic [CELLS-1:0]        cell_valid,
    output logic [CELLS*WORD_W-1:0] cell_ctx
);
    logic             wr_accept;
    logic [BUS_W-1:0] plane_words [2];

    ctx_write_guard u_guard (
        .clk        (clk),
        .rst_n      (rst_n),
        .exec_valid (exec_valid),
        .exec_mode  (exec_mode),
        .wr_valid   (wr_valid),
        .wr_plane   (wr_plane),
        .wr_accept  (wr_accept),
        .wr_error   (wr_error)
    );

    for (genvar p = 0; p < 2; p++) begin : g_plane
        logic bank_wr;
        logic bank_rd;

        assign bank_wr = wr_accept && (wr_plane == 1'(p));
        assign bank_rd = exec_valid && (exec_mode == 1'(p));

        ctx_plane_bank #(
            .LINES  (LINES),
            .DEPTH  (DEPTH),
            .WORD_W (WORD_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (bank_wr),
            .wr_set   (wr_set),
            .wr_index (wr_index),
            .wr_data  (wr_data),
            .rd_en    (bank_rd),
            .rd_index (exec_index),
            .rd_words (plane_words[p])
        );
    end

    // Register the broadcast mode and the per-cell strobe for each execute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_mode   <= PLANE_ROW;
            cell_valid <= '0;
        end else begin
            cell_valid <= {CELLS{exec_valid}};
            if (exec_valid) begin
                bus_mode <= exec_mode;
            end
        end
    end

    // Drive the bus from the plane that served the latest execute
    always_comb begin
        ctx_bus = (bus_mode == PLANE_COL) ? plane_words[1] : plane_words[0];
    end

    ctx_cell_fanout #(
        .LINES  (LINES),
        .WORD_W (WORD_W)
    ) u_fanout (
        .bus_mode (bus_mode),
        .ctx_bus  (ctx_bus),
        .cell_ctx (cell_ctx)
    );
endmodule

// File: rtl/ctx_broadcast_mem_chk.sv
// Module: assertion checker for ctx_broadcast_mem, attached with bind.
// It observes the top-level ports only.
module ctx_broadcast_mem_chk #(
    parameter int unsigned LINES  = 8,
    parameter int unsigned WORD_W = 32,
    parameter int unsigned IDX_W  = 4,
    parameter int unsigned SET_W  = 3
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            exec_valid,
    input logic                            exec_mode,
    input logic [IDX_W-1:0]                exec_index,
    input logic                            wr_valid,
    input logic                            wr_plane,
    input logic [SET_W-1:0]                wr_set,
    input logic                            wr_error,
    input logic [LINES*WORD_W-1:0]         ctx_bus,
    input logic                            bus_mode,
    input logic [LINES*LINES-1:0]          cell_valid,
    input logic [LINES*LINES*WORD_W-1:0]   cell_ctx
);
    localparam int unsigned LAST = LINES - 1;

    // R6: every cell is strobed on the edge after an execute
    p_strobe_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> (&cell_valid));

    // R6: no strobe without an execute
    p_strobe_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> (cell_valid == '0));

    // R6: the bus mode follows the command's mode
    p_mode_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        exec_valid |=> (bus_mode == $past(exec_mode)));

    // R7: bus contents hold between executes
    p_bus_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !exec_valid |=> ($stable(ctx_bus) && $stable(bus_mode)));

    // R8: a write against the plane being executed is flagged
    p_same_cycle_reject_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && exec_valid && (wr_plane == exec_mode)) |=> wr_error);

    // R8: an error only ever follows a write request
    p_error_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_error |-> $past(wr_valid));

    // R4: in row mode the far cell of row 0 carries lane 0
    p_row_fanout_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_mode |-> (cell_ctx[LAST*WORD_W +: WORD_W] == ctx_bus[0 +: WORD_W]));

    // R5: in column mode the far cell of row 0 carries the last column's lane
    p_col_fanout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        bus_mode |-> (cell_ctx[LAST*WORD_W +: WORD_W] == ctx_bus[LAST*WORD_W +: WORD_W]));

    logic unused_ok;
    assign unused_ok = ^{exec_index, wr_set};
endmodule

bind ctx_broadcast_mem ctx_broadcast_mem_chk #(
    .LINES  (LINES),
    .WORD_W (WORD_W),
    .IDX_W  (IDX_W),
    .SET_W  (SET_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .exec_valid (exec_valid),
    .exec_mode  (exec_mode),
    .exec_index (exec_index),
    .wr_valid   (wr_valid),
    .wr_plane   (wr_plane),
    .wr_set     (wr_set),
    .wr_error   (wr_error),
    .ctx_bus    (ctx_bus),
    .bus_mode   (bus_mode),
    .cell_valid (cell_valid),
    .cell_ctx   (cell_ctx)
);

// File: tb/ctx_broadcast_mem_tb.sv
// Bench: directed scenarios for ctx_broadcast_mem. Inputs change on the falling
// edge and outputs are sampled on the falling edge that follows.
module ctx_broadcast_mem_tb;
    localparam int L = 8;
    localparam int D = 16;
    localparam int W = 32;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           exec_valid = 1'b0;
    logic           exec_mode = 1'b0;
    logic [3:0]     exec_index = '0;
    logic           wr_valid = 1'b0;
    logic           wr_plane = 1'b0;
    logic [2:0]     wr_set = '0;
    logic [3:0]     wr_index = '0;
    logic [W-1:0]   wr_data = '0;
    logic           wr_error;
    logic [L*W-1:0] ctx_bus;
    logic           bus_mode;
    logic [L*L-1:0] cell_valid;
    logic [L*L*W-1:0] cell_ctx;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_mem [2][L][D];

    always #5 clk = ~clk;

    ctx_broadcast_mem u_dut (
        .clk(clk), .rst_n(rst_n),
        .exec_valid(exec_valid), .exec_mode(exec_mode), .exec_index(exec_index),
        .wr_valid(wr_valid), .wr_plane(wr_plane), .wr_set(wr_set),
        .wr_index(wr_index), .wr_data(wr_data), .wr_error(wr_error),
        .ctx_bus(ctx_bus), .bus_mode(bus_mode),
        .cell_valid(cell_valid), .cell_ctx(cell_ctx)
    );

    function automatic logic [W-1:0] pat(int p, int s, int i, int gen);
        return {4'(p + 1), 4'(gen), 4'(s), 4'(i), 16'(16'hC0DE ^ 16'(s*293 + i*37 + p*1111 + gen*77))};
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] expv);
        checks++;
        if (act !== expv) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, expv);
        end
    endtask

    // Write one word; check wr_error on the following edge
    task automatic do_write(int p, int s, int i, logic [W-1:0] d, bit expect_err, string req);
        @(negedge clk);
        wr_valid = 1'b1; wr_plane = 1'(p); wr_set = 3'(s); wr_index = 4'(i); wr_data = d;
        @(negedge clk);
        wr_valid = 1'b0;
        chk(req, 64'(wr_error), 64'(expect_err));
        if (!expect_err) exp_mem[p][s][i] = d;
        else begin
            @(negedge clk);
            chk({req, " error lasts one cycle"}, 64'(wr_error), 64'd0);
        end
    endtask

    // Check the bus lanes, the strobe and every cell against the model
    task automatic check_bus(int m, int idx, string req_bus, string req_fan);
        for (int k = 0; k < L; k++)
            chk(req_bus, 64'(ctx_bus[k*W +: W]), 64'(exp_mem[m][k][idx]));
        chk("R6 mode", 64'(bus_mode), 64'(m));
        chk("R6 strobe high", 64'(cell_valid), {64{1'b1}});
        for (int r = 0; r < L; r++)
            for (int c = 0; c < L; c++)
                chk(req_fan, 64'(cell_ctx[(r*L+c)*W +: W]),
                    64'(exp_mem[m][(m == 1) ? c : r][idx]));
    endtask

    // Execute one index; check data and strobe, then the hold cycle
    task automatic do_exec(int m, int idx, string req_bus, string req_fan);
        logic [L*W-1:0] snap;
        @(negedge clk);
        exec_valid = 1'b1; exec_mode = 1'(m); exec_index = 4'(idx);
        @(negedge clk);
        exec_valid = 1'b0;
        check_bus(m, idx, req_bus, req_fan);
        snap = ctx_bus;
        @(negedge clk);
        chk("R6 strobe one cycle", 64'(cell_valid), 64'd0);
        checks++;
        if (ctx_bus !== snap) begin
            errors++;
            $display("FAIL R7: bus changed actual=%0h expected=%0h", ctx_bus, snap);
        end
    endtask

    // Execute and write the same plane in one cycle; the write must be refused
    task automatic exec_with_write(int m, int idx, int s, logic [W-1:0] d);
        @(negedge clk);
        exec_valid = 1'b1; exec_mode = 1'(m); exec_index = 4'(idx);
        wr_valid = 1'b1; wr_plane = 1'(m); wr_set = 3'(s); wr_index = 4'(idx); wr_data = d;
        @(negedge clk);
        exec_valid = 1'b0; wr_valid = 1'b0;
        chk("R8 same-cycle reject", 64'(wr_error), 64'd1);
        check_bus(m, idx, "R8 bus unaffected", "R8 cells unaffected");
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 bus", 64'(ctx_bus[63:0]), 64'd0);
        chk("R1 bus high", 64'(|ctx_bus), 64'd0);
        chk("R1 cells", 64'(|cell_ctx), 64'd0);
        chk("R1 strobe", 64'(cell_valid), 64'd0);
        chk("R1 mode", 64'(bus_mode), 64'd0);
        chk("R1 error", 64'(wr_error), 64'd0);
    endtask

    task automatic t_load_all();
        for (int p = 0; p < 2; p++)
            for (int s = 0; s < L; s++)
                for (int i = 0; i < D; i++)
                    do_write(p, s, i, pat(p, s, i, 0), 1'b0, "R9 load before execute");
    endtask

    task automatic t_row_exec();
        do_exec(0, 0, "R2 row bus", "R4 row fanout");
        do_exec(0, 5, "R2 row bus", "R4 row fanout");
        do_exec(0, 15, "R2 row bus", "R4 row fanout");
    endtask

    task automatic t_col_exec();
        do_exec(1, 5, "R3 col bus", "R5 col fanout");
        do_exec(1, 15, "R3 col bus", "R5 col fanout");
        // R10: same index, different planes hold different words
        chk("R10 planes distinct", 64'(exp_mem[0][3][5] != exp_mem[1][3][5]), 64'd1);
    endtask

    task automatic t_live_protect();
        // Column plane is live: the write is refused and stored data survive
        do_write(1, 2, 3, 32'hDEAD_BEEF, 1'b1, "R8 live reject");
        do_exec(1, 3, "R8 live data kept", "R5 col fanout");
        // Row plane is idle: write accepted while the bus holds column data
        do_write(0, 4, 7, pat(0, 4, 7, 1), 1'b0, "R9 idle accept");
        chk("R7 bus mode held across write", 64'(bus_mode), 64'd1);
        do_exec(0, 7, "R9 new row word", "R4 row fanout");
        // Now the column plane is idle and writable
        do_write(1, 2, 3, pat(1, 2, 3, 2), 1'b0, "R9 idle accept col");
        do_exec(1, 3, "R9 new col word", "R5 col fanout");
        do_exec(0, 3, "R10 row unaffected", "R4 row fanout");
    endtask

    task automatic t_same_cycle();
        exec_with_write(1, 9, 6, 32'h0BAD_F00D);
        do_exec(1, 9, "R8 same-cycle data kept", "R5 col fanout");
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_load_all();
                t_row_exec();
                t_col_exec();
                t_live_protect();
                t_same_cycle();
            end
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog: actual=timeout expected=completion");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule